// File: doc/BRIEF.md
# Dual-Issue Pairing Check

This unit sits behind an in-order decode stage and looks at the two oldest decoded instructions each cycle. It decides whether both may enter the two parallel execution pipes together. The older instruction always goes to the primary pipe (U). The younger goes to the secondary pipe (V) only when the pair passes every pairing rule. Both instructions must be simple, which means neither needs microcode sequencing. The older one must not transfer control. The younger one must not need a resource that only the U pipe has. The two must not conflict on registers.

The unit reports a pointer-advance count to the decode queue in the same cycle: 2 when the pair issues, 1 when only the older instruction issues, and 0 when nothing issues. When pairing is refused, the younger instruction stays in the queue. On the next cycle it becomes the older slot and may pair with the instruction behind it.

The pipe-entry registers load on the clock edge that follows the decision. While a downstream stall is asserted they hold their contents and the advance count is 0.

Top module: `dual_issue_pair`

## Requirements
- R1: While reset is low, and on every edge where no stall is asserted and `s0Valid` is 0, `uValid` and `vValid` are 0 after the edge, and `advance` is 0 in that cycle.
- R2: A pair is refused unless both `s0Simple` and `s1Simple` are 1.
- R3: A pair is refused when the older instruction has `s0Jump` or `s0CondJump` set. A conditional jump in the younger slot (`s1CondJump` = 1) does not by itself prevent pairing.
- R4: A pair is refused when any younger source with its valid bit set names the register that the older instruction writes (with `s0DstValid` = 1). Every source position is compared.
- R5: A pair is refused when both destination valid bits are set and `s0Dst` equals `s1Dst`.
- R6: An older instruction that sets condition codes (`s0SetsFlags` = 1), followed by a younger conditional jump, pairs when R2 through R5 and R7 allow it.
- R7: A younger instruction with `s1UOnly` = 1 is never paired, so it never enters the V pipe.
- R8: With no stall and `s0Valid` = 1:
  - If pairing is allowed, `pairIssued` and `advance` = 2 are shown combinationally. After the next edge, `uPayload` = `s0Payload`, `vPayload` = `s1Payload`, and both valid outputs are 1.
  - If pairing is refused, `advance` = 1 and `pairIssued` = 0. After the next edge, `uPayload` = `s0Payload`, `uValid` = 1 and `vValid` = 0.
- R9: While `stall` is 1, `advance` is 0 and `pairIssued` is 0, and the pipe-entry outputs keep their values across the edge.
- R10: A source or destination field whose valid bit is 0 takes no part in the conflict checks of R4 and R5.
- R11: With `s0Valid` = 1 and `s1Valid` = 0, the older instruction issues alone to U with `advance` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Downstream stall; holds issue |
| s0Valid | input | 1 | Older slot holds an instruction |
| s0Simple | input | 1 | Older instruction needs no microcode |
| s0Jump | input | 1 | Older instruction is a jump |
| s0CondJump | input | 1 | Older instruction is a conditional jump |
| s0SetsFlags | input | 1 | Older instruction writes condition codes |
| s0DstValid | input | 1 | Older destination field is meaningful |
| s0Dst | input | RW (3) | Older destination register |
| s0Payload | input | PW (8) | Older instruction word routed to a pipe |
| s1Valid | input | 1 | Younger slot holds an instruction |
| s1Simple | input | 1 | Younger instruction needs no microcode |
| s1CondJump | input | 1 | Younger instruction is a conditional jump |
| s1UOnly | input | 1 | Younger instruction needs U-only resources |
| s1DstValid | input | 1 | Younger destination field is meaningful |
| s1Dst | input | RW (3) | Younger destination register |
| s1SrcValid | input | NSRC (2) | Valid bit per younger source |
| s1Src | input | NSRC x RW (6) | Younger source registers |
| s1Payload | input | PW (8) | Younger instruction word |
| pairIssued | output | 1 | Both slots issue this cycle |
| advance | output | 2 | Queue pointer advance: 0, 1 or 2 |
| uValid | output | 1 | U pipe entry holds an instruction |
| uPayload | output | PW (8) | Instruction in U pipe entry |
| vValid | output | 1 | V pipe entry holds an instruction |
| vPayload | output | PW (8) | Instruction in V pipe entry |

## Verification
The main sweep holds the older slot valid and walks every combination of the seven descriptor flags and the four field valid bits. It does this with the younger slot both present and absent. Every register field is drawn from two distinct values, so each field either matches or misses each other field. This shows which single rule blocks a given pair, in the priority order of R2, R3, R7, R4, R5. It also shows the flag-producer/conditional-jump case apart from a true register conflict. Because the sweep covers the cases where a matching field has its valid bit cleared, it catches a comparator that ignores the valid bits. Directed sequences then apply a stall after a paired issue, and an empty older slot, to confirm that the pipe entries hold and that nothing issues.

// File: rtl/pair_pkg.sv
package pair_pkg;

  // Strobes from the pairing control into the pipe-entry datapath
  typedef struct packed {
    logic loadU;  // older slot enters the U pipe
    logic loadV;  // younger slot enters the V pipe
    logic hold;   // keep current pipe-entry contents
  } issueCtl_t;

endpackage

// File: rtl/pair_ctrl.sv
module pair_ctrl
  import pair_pkg::*;
#(
  parameter int NREGS = 8,
  parameter int NSRC  = 2,
  localparam int RW   = $clog2(NREGS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     stall,
  input  logic                     s0Valid,
  input  logic                     s0Simple,
  input  logic                     s0Jump,
  input  logic                     s0CondJump,
  input  logic                     s0SetsFlags,
  input  logic                     s0DstValid,
  input  logic [RW-1:0]            s0Dst,
  input  logic                     s1Valid,
  input  logic                     s1Simple,
  input  logic                     s1CondJump,
  input  logic                     s1UOnly,
  input  logic                     s1DstValid,
  input  logic [RW-1:0]            s1Dst,
  input  logic [NSRC-1:0]          s1SrcValid,
  input  logic [NSRC-1:0][RW-1:0]  s1Src,
  output issueCtl_t                ctl,
  output logic                     pairIssued,
  output logic [1:0]               advance
);

  logic [NSRC-1:0] srcHit;
  logic rawConflict, wawConflict, bothSimple, firstBranches, pairOk;

  // One comparator per younger source against the older destination
  for (genvar i = 0; i < NSRC; i++) begin : g_srcCmp
    assign srcHit[i] = s1SrcValid[i] && (s1Src[i] == s0Dst);
  end

  always_comb begin
    rawConflict   = s0DstValid && (|srcHit);
    wawConflict   = s0DstValid && s1DstValid && (s0Dst == s1Dst);
    bothSimple    = s0Simple && s1Simple;
    firstBranches = s0Jump || s0CondJump;
    pairOk = s0Valid && s1Valid && bothSimple && !firstBranches &&
             !s1UOnly && !rawConflict && !wawConflict;
  end

  always_comb begin
    ctl.hold   = stall;
    ctl.loadU  = s0Valid && !stall;
    ctl.loadV  = pairOk && !stall;
    pairIssued = ctl.loadV;
    if (stall || !s0Valid) advance = 2'd0;
    else if (pairOk)       advance = 2'd2;
    else                   advance = 2'd1;
  end

  // A U-only instruction in the younger slot never issues alongside
  assert_uonly_never_v_R7: assert property (@(posedge clk) disable iff (!rstN)
    s1UOnly |-> !pairIssued);

  // An older control transfer never pairs
  assert_no_jump_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    (s0Jump || s0CondJump) |-> !pairIssued);

  // Flag producer followed by a conditional jump still pairs
  assert_flag_pair_R6: assert property (@(posedge clk) disable iff (!rstN)
    (s0Valid && s1Valid && s0Simple && s1Simple && !s0Jump && !s0CondJump &&
     !s1UOnly && !s0DstValid && s0SetsFlags && s1CondJump && !stall)
    |-> pairIssued);

  // A pair always retires two queue entries
  assert_pair_advance_R8: assert property (@(posedge clk) disable iff (!rstN)
    pairIssued |-> (advance == 2'd2));

  // Stall freezes the queue pointer
  assert_stall_advance_R9: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (advance == 2'd0 && !pairIssued));

endmodule

// File: rtl/pair_datapath.sv
module pair_datapath
  import pair_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  issueCtl_t     ctl,
  input  logic [PW-1:0] s0Payload,
  input  logic [PW-1:0] s1Payload,
  output logic          uValid,
  output logic [PW-1:0] uPayload,
  output logic          vValid,
  output logic [PW-1:0] vPayload
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      uValid   <= 1'b0;
      vValid   <= 1'b0;
      uPayload <= '0;
      vPayload <= '0;
    end else if (!ctl.hold) begin
      uValid <= ctl.loadU;
      vValid <= ctl.loadV;
      if (ctl.loadU) uPayload <= s0Payload;
      if (ctl.loadV) vPayload <= s1Payload;
    end
  end

  // The V entry is only ever filled together with the U entry
  assert_v_needs_u_R8: assert property (@(posedge clk) disable iff (!rstN)
    vValid |-> uValid);

  // Held entries do not change across a stalled edge
  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.hold |=> ($stable(uValid) && $stable(vValid) &&
                  $stable(uPayload) && $stable(vPayload)));

endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
  import pair_pkg::*;
#(
  parameter int NREGS = 8,
  parameter int NSRC  = 2,
  parameter int PW    = 8,
  localparam int RW   = $clog2(NREGS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     stall,
  input  logic                     s0Valid,
  input  logic                     s0Simple,
  input  logic                     s0Jump,
  input  logic                     s0CondJump,
  input  logic                     s0SetsFlags,
  input  logic                     s0DstValid,
  input  logic [RW-1:0]            s0Dst,
  input  logic [PW-1:0]            s0Payload,
  input  logic                     s1Valid,
  input  logic                     s1Simple,
  input  logic                     s1CondJump,
  input  logic                     s1UOnly,
  input  logic                     s1DstValid,
  input  logic [RW-1:0]            s1Dst,
  input  logic [NSRC-1:0]          s1SrcValid,
  input  logic [NSRC-1:0][RW-1:0]  s1Src,
  input  logic [PW-1:0]            s1Payload,
  output logic                     pairIssued,
  output logic [1:0]               advance,
  output logic                     uValid,
  output logic [PW-1:0]            uPayload,
  output logic                     vValid,
  output logic [PW-1:0]            vPayload
);

  issueCtl_t ctl;

  pair_ctrl #(.NREGS(NREGS), .NSRC(NSRC)) u_ctrl (
    .clk(clk), .rstN(rstN), .stall(stall),
    .s0Valid(s0Valid), .s0Simple(s0Simple), .s0Jump(s0Jump),
    .s0CondJump(s0CondJump), .s0SetsFlags(s0SetsFlags),
    .s0DstValid(s0DstValid), .s0Dst(s0Dst),
    .s1Valid(s1Valid), .s1Simple(s1Simple), .s1CondJump(s1CondJump),
    .s1UOnly(s1UOnly), .s1DstValid(s1DstValid), .s1Dst(s1Dst),
    .s1SrcValid(s1SrcValid), .s1Src(s1Src),
    .ctl(ctl), .pairIssued(pairIssued), .advance(advance)
  );

  pair_datapath #(.PW(PW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .s0Payload(s0Payload), .s1Payload(s1Payload),
    .uValid(uValid), .uPayload(uPayload),
    .vValid(vValid), .vPayload(vPayload)
  );

endmodule

// File: tb/tb_dual_issue_pair.sv
module tb_dual_issue_pair;

  localparam int CLK_PERIOD = 10;
  localparam int RW = 3;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stall = 1'b0;
  logic s0Valid = 0, s0Simple = 0, s0Jump = 0, s0CondJump = 0, s0SetsFlags = 0, s0DstValid = 0;
  logic [RW-1:0] s0Dst = '0;
  logic [PW-1:0] s0Payload = '0;
  logic s1Valid = 0, s1Simple = 0, s1CondJump = 0, s1UOnly = 0, s1DstValid = 0;
  logic [RW-1:0] s1Dst = '0;
  logic [1:0] s1SrcValid = '0;
  logic [1:0][RW-1:0] s1Src = '0;
  logic [PW-1:0] s1Payload = '0;
  logic pairIssued;
  logic [1:0] advance;
  logic uValid, vValid;
  logic [PW-1:0] uPayload, vPayload;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_issue_pair dut (
    .clk(clk), .rstN(rstN), .stall(stall),
    .s0Valid(s0Valid), .s0Simple(s0Simple), .s0Jump(s0Jump),
    .s0CondJump(s0CondJump), .s0SetsFlags(s0SetsFlags),
    .s0DstValid(s0DstValid), .s0Dst(s0Dst), .s0Payload(s0Payload),
    .s1Valid(s1Valid), .s1Simple(s1Simple), .s1CondJump(s1CondJump),
    .s1UOnly(s1UOnly), .s1DstValid(s1DstValid), .s1Dst(s1Dst),
    .s1SrcValid(s1SrcValid), .s1Src(s1Src), .s1Payload(s1Payload),
    .pairIssued(pairIssued), .advance(advance),
    .uValid(uValid), .uPayload(uPayload), .vValid(vValid), .vPayload(vPayload)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Independent reference of the pairing rules; tag names the deciding rule
  function automatic bit refPair(output string tag);
    bit srcA, srcB;
    srcA = s1SrcValid[0] && (s1Src[0] == s0Dst);
    srcB = s1SrcValid[1] && (s1Src[1] == s0Dst);
    if (!s1Valid) begin tag = "R11"; return 0; end
    if (!(s0Simple && s1Simple)) begin tag = "R2"; return 0; end
    if (s0Jump || s0CondJump) begin tag = "R3"; return 0; end
    if (s1UOnly) begin tag = "R7"; return 0; end
    if (s0DstValid && (srcA || srcB)) begin tag = "R4"; return 0; end
    if (s0DstValid && s1DstValid && (s0Dst == s1Dst)) begin tag = "R5"; return 0; end
    if (s0SetsFlags && s1CondJump) tag = "R6";
    else if (!(s0DstValid && s1DstValid && s1SrcValid[0] && s1SrcValid[1])) tag = "R10";
    else tag = "R8";
    return 1;
  endfunction

  function automatic logic [RW-1:0] regOf(input bit sel);
    return sel ? 3'd5 : 3'd2;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    string tag;
    bit expPair;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(uValid == 0 && vValid == 0, "R1", "valid in reset", {uValid, vValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(advance == 0, "R1", "advance idle", advance, 0);
    @(posedge clk); #1;
    check(uValid == 0 && vValid == 0, "R1", "valid idle", {uValid, vValid}, 0);
    @(negedge clk);

    // Main sweep: older slot always valid
    for (int v = 0; v < 65536; v++) begin
      s0Valid = 1'b1;
      s0Simple = v[0]; s0Jump = v[1]; s0CondJump = v[2]; s0SetsFlags = v[3];
      s1Simple = v[4]; s1CondJump = v[5]; s1UOnly = v[6];
      s0DstValid = v[7]; s1DstValid = v[8]; s1SrcValid = v[10:9];
      s0Dst = regOf(v[11]); s1Dst = regOf(v[12]);
      s1Src[0] = regOf(v[13]); s1Src[1] = regOf(v[14]);
      s1Valid = v[15];
      s0Payload = v[7:0]; s1Payload = ~v[15:8];
      expPair = refPair(tag);
      #1;
      check(pairIssued == expPair, tag, "pairIssued", pairIssued, expPair);
      check(advance == (expPair ? 2 : 1), tag, "advance", advance, expPair ? 2 : 1);
      @(posedge clk); #1;
      check(uValid == 1 && uPayload == s0Payload, "R8", "U entry", uPayload, s0Payload);
      check(vValid == expPair, tag, "vValid", vValid, expPair);
      if (expPair)
        check(vPayload == s1Payload, "R8", "V payload", vPayload, s1Payload);
      @(negedge clk);
    end

    // R9: stall after a paired issue holds everything
    s0Simple = 1; s1Simple = 1; s0Jump = 0; s0CondJump = 0; s1UOnly = 0;
    s0DstValid = 0; s1DstValid = 0; s1SrcValid = '0; s1Valid = 1;
    s0Payload = 8'hA1; s1Payload = 8'hB2;
    @(posedge clk); #1;
    check(vValid && vPayload == 8'hB2, "R8", "pre-stall pair", vPayload, 8'hB2);
    @(negedge clk);
    stall = 1; s0Payload = 8'h11; s1Payload = 8'h22;
    #1;
    check(advance == 0, "R9", "advance in stall", advance, 0);
    check(pairIssued == 0, "R9", "pair in stall", pairIssued, 0);
    @(posedge clk); #1;
    check(uValid && uPayload == 8'hA1, "R9", "U held", uPayload, 8'hA1);
    check(vValid && vPayload == 8'hB2, "R9", "V held", vPayload, 8'hB2);
    @(negedge clk);

    // R1: empty older slot issues nothing
    stall = 0; s0Valid = 0;
    #1;
    check(advance == 0 && pairIssued == 0, "R1", "advance empty", advance, 0);
    @(posedge clk); #1;
    check(uValid == 0 && vValid == 0, "R1", "entries empty", {uValid, vValid}, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule